// File: doc/BRIEF.md
# Triple-Redundant Configuration Load Sequencer

This block is a small control state machine that steps a configuration transfer through four phases. It waits for a start request, then issues a fixed number of word-load strobes with an ascending word index. It then gives a single commit strobe and reports completion until the request is withdrawn. It is meant for parts of a chip where a particle strike can flip a flip-flop, so the state machine is built three times over.

Each of the three copies keeps its own state register and computes its own next state and control outputs from it. A bitwise two-of-three majority vote combines the three next-state values, and every copy loads the voted result. A copy that was disturbed therefore agrees with the other two again after one clock edge. The control outputs of the copies are voted separately and then registered once before they leave the block. A flag pulses when the three state registers did not all agree during a cycle.

Top module: `tmr_cfg_seq`

## Requirements
- R1: Reset is synchronous and active high. After any clock edge at which `rst_i` is high, all outputs are 0 and the sequencer is idle.
- R2: While idle and `start_i` is low, `load_en_o`, `apply_o` and `done_o` stay 0.
- R3: When `start_i` is sampled high while idle, `load_en_o` is high for exactly NUM_WORDS consecutive cycles beginning two clock edges later. During those cycles `load_addr_o` counts 0, 1, … NUM_WORDS-1, and it reads 0 whenever `load_en_o` is low.
- R4: `apply_o` is high for exactly one cycle, immediately after the cycle with the last load index.
- R5: `done_o` rises in the cycle after `apply_o` and stays high until `start_i` has been sampled low. No load or apply strobe follows a done cycle directly.
- R6: `start_i` has no effect while loading or applying: a sequence that has begun always runs to completion.
- R7: An inverted bit in the state register of any single copy leaves every control output identical to a fault-free run.
- R8: A disturbed copy is corrected at the next clock edge, so upsets in two different copies on consecutive cycles are both masked.
- R9: `mismatch_o` is high in the cycle after a clock edge at which the three state registers did not all hold the same value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to run one load sequence |
| load_en_o | output | 1 | Word-load strobe |
| load_addr_o | output | CNT_W = clog2(NUM_WORDS) | Index of the word being loaded |
| apply_o | output | 1 | One-cycle commit strobe |
| done_o | output | 1 | Sequence finished, held until start is withdrawn |
| mismatch_o | output | 1 | The copies disagreed in the previous cycle |

## Verification
A wrong state held by one copy never reaches the control outputs. It appears only as a single-cycle pulse on `mismatch_o`, one edge after the upset, and that copy is back in step at the same edge. A wrong voted state, or a broken voter, appears two edges later as a skipped or repeated load index, a missing or doubled commit strobe, or a done phase that never ends. The bench therefore injects upsets at chosen cycles and compares every output cycle by cycle against a fault-free expectation.

// File: rtl/tmr_seq_pkg.sv
package tmr_seq_pkg;

    // number of redundant copies; the voter is a fixed two-of-three majority
    localparam int N_COPY = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_APPLY = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

endpackage

// File: rtl/tmr_maj3.sv
module tmr_maj3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);

    // per-bit two-of-three majority
    for (genvar bit_idx = 0; bit_idx < W; bit_idx++) begin : g_bit
        assign y_o[bit_idx] = (a_i[bit_idx] & b_i[bit_idx])
                            | (a_i[bit_idx] & c_i[bit_idx])
                            | (b_i[bit_idx] & c_i[bit_idx]);
    end

endmodule

// File: rtl/tmr_seq_copy.sv
module tmr_seq_copy
    import tmr_seq_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int CNT_W     = 3,
    localparam int SW       = 2 + CNT_W,
    localparam int CW       = CNT_W + 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [SW-1:0] voted_i,
    output logic [SW-1:0] next_o,
    output logic [CW-1:0] ctrl_o,
    output logic [SW-1:0] state_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } st_t;

    typedef struct packed {
        logic             load_en;
        logic [CNT_W-1:0] addr;
        logic             apply;
        logic             done;
    } ctl_t;

    logic [SW-1:0] st_q;
    logic [SW-1:0] st_d;
    st_t           cur;
    st_t           nxt;
    ctl_t          ctl;

    always_comb begin
        cur  = st_t'(st_q);
        nxt  = cur;
        ctl  = '0;
        // the register of every copy loads the voted next state
        st_d = voted_i;
        case (cur.ph)
            PH_IDLE: begin
                if (start_i) begin
                    nxt.ph  = PH_LOAD;
                    nxt.cnt = '0;
                end
            end
            PH_LOAD: begin
                ctl.load_en = 1'b1;
                ctl.addr    = cur.cnt;
                if (cur.cnt == LAST) begin
                    nxt.ph  = PH_APPLY;
                    nxt.cnt = '0;
                end else begin
                    nxt.cnt = cur.cnt + 1'b1;
                end
            end
            PH_APPLY: begin
                ctl.apply = 1'b1;
                nxt.ph    = PH_DONE;
                nxt.cnt   = '0;
            end
            PH_DONE: begin
                ctl.done = 1'b1;
                if (!start_i) begin
                    nxt.ph  = PH_IDLE;
                    nxt.cnt = '0;
                end
            end
            default: begin
                nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_o  = nxt;
    assign ctrl_o  = ctl;
    assign state_o = st_q;

endmodule

// File: rtl/tmr_cfg_seq.sv
module tmr_cfg_seq
    import tmr_seq_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    localparam int CNT_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    output logic             load_en_o,
    output logic [CNT_W-1:0] load_addr_o,
    output logic             apply_o,
    output logic             done_o,
    output logic             mismatch_o
);

    localparam int SW = 2 + CNT_W;
    localparam int CW = CNT_W + 3;

    typedef struct packed {
        logic [CW-1:0] ctl;
        logic          mis;
    } out_t;

    logic [SW-1:0] nxt_w   [N_COPY];
    logic [SW-1:0] state_w [N_COPY];
    logic [CW-1:0] ctl_w   [N_COPY];
    logic [SW-1:0] voted_st;
    logic [CW-1:0] voted_ctl;
    out_t          out_d;
    out_t          out_q;

    for (genvar g = 0; g < N_COPY; g++) begin : g_copy
        tmr_seq_copy #(
            .NUM_WORDS (NUM_WORDS),
            .CNT_W     (CNT_W)
        ) i_copy (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .start_i (start_i),
            .voted_i (voted_st),
            .next_o  (nxt_w[g]),
            .ctrl_o  (ctl_w[g]),
            .state_o (state_w[g])
        );
    end

    tmr_maj3 #(.W(SW)) i_vote_state (
        .a_i (nxt_w[0]),
        .b_i (nxt_w[1]),
        .c_i (nxt_w[2]),
        .y_o (voted_st)
    );

    tmr_maj3 #(.W(CW)) i_vote_ctrl (
        .a_i (ctl_w[0]),
        .b_i (ctl_w[1]),
        .c_i (ctl_w[2]),
        .y_o (voted_ctl)
    );

    always_comb begin
        out_d.ctl = voted_ctl;
        out_d.mis = (state_w[0] != state_w[1]) || (state_w[1] != state_w[2]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign {load_en_o, load_addr_o, apply_o, done_o} = out_q.ctl;
    assign mismatch_o = out_q.mis;

endmodule

// File: rtl/tmr_cfg_seq_chk.sv
module tmr_cfg_seq_chk #(
    parameter int NUM_WORDS = 8,
    localparam int CNT_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic             load_en_o,
    input logic [CNT_W-1:0] load_addr_o,
    input logic             apply_o,
    input logic             done_o,
    input logic             mismatch_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

    // R3: at most one phase strobe at a time
    a_r3_one_phase: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({load_en_o, apply_o, done_o}));

    // R3: consecutive load cycles step the index by one
    a_r3_addr_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_en_o && $past(load_en_o)) |-> (load_addr_o == CNT_W'($past(load_addr_o) + 1'b1)));

    // R3: index reads zero outside the load phase
    a_r3_addr_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_en_o |-> (load_addr_o == '0));

    // R4: commit follows the last load index
    a_r4_apply_after_last: assert property (@(posedge clk_i) disable iff (rst_i)
        apply_o |-> ($past(load_en_o) && ($past(load_addr_o) == LAST)));

    // R5: done follows the commit strobe
    a_r5_done_after_apply: assert property (@(posedge clk_i) disable iff (rst_i)
        apply_o |=> (done_o && !apply_o));

    // R5: no strobe directly after a done cycle
    a_r5_done_exit: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (!load_en_o && !apply_o));

    // R9: no disagreement can exist on the first cycle out of reset
    a_r9_quiet_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !mismatch_o);

endmodule

bind tmr_cfg_seq tmr_cfg_seq_chk #(.NUM_WORDS(NUM_WORDS)) i_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .load_en_o   (load_en_o),
    .load_addr_o (load_addr_o),
    .apply_o     (apply_o),
    .done_o      (done_o),
    .mismatch_o  (mismatch_o)
);

// File: tb/test_tmr_cfg_seq.sv
module test_tmr_cfg_seq;

    localparam int NW = 8;
    localparam int CW = 3;
    localparam int SW = 2 + CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          load_en;
    logic [CW-1:0] load_addr;
    logic          apply;
    logic          done;
    logic          mismatch;
    logic [SW-1:0] upset_val;

    int  n_checks = 0;
    int  n_errors = 0;
    int  cyc      = 0;
    bit  mon_on   = 1'b0;
    bit  finished = 1'b0;

    // model state: 0 idle, 1 load, 2 apply, 3 done
    int  m_ph  = 0;
    int  m_cnt = 0;

    typedef struct {
        int    stamp;
        bit    le;
        int    addr;
        bit    ap;
        bit    dn;
        string req;
    } item_t;

    item_t exp_q[$];
    int    mis_q[$];

    tmr_cfg_seq #(.NUM_WORDS(NW)) i_tmr_cfg_seq (
        .clk_i       (clk),
        .rst_i       (rst),
        .start_i     (start),
        .load_en_o   (load_en),
        .load_addr_o (load_addr),
        .apply_o     (apply),
        .done_o      (done),
        .mismatch_o  (mismatch)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // driver: drive one cycle of stimulus, optionally flip a state bit in one copy,
    // and push the output expected two edges later
    task automatic tick(input bit s, input bit r, input int inj,
                        input logic [SW-1:0] mask, input string tag);
        item_t it;
        @(posedge clk);
        #5;
        start = s;
        rst   = r;
        if (inj >= 0) begin
            case (inj)
                0: begin
                    upset_val = i_tmr_cfg_seq.g_copy[0].i_copy.st_q ^ mask;
                    force i_tmr_cfg_seq.g_copy[0].i_copy.st_q = upset_val;
                    #1 release i_tmr_cfg_seq.g_copy[0].i_copy.st_q;
                end
                1: begin
                    upset_val = i_tmr_cfg_seq.g_copy[1].i_copy.st_q ^ mask;
                    force i_tmr_cfg_seq.g_copy[1].i_copy.st_q = upset_val;
                    #1 release i_tmr_cfg_seq.g_copy[1].i_copy.st_q;
                end
                default: begin
                    upset_val = i_tmr_cfg_seq.g_copy[2].i_copy.st_q ^ mask;
                    force i_tmr_cfg_seq.g_copy[2].i_copy.st_q = upset_val;
                    #1 release i_tmr_cfg_seq.g_copy[2].i_copy.st_q;
                end
            endcase
            mis_q.push_back(cyc + 1);
        end
        if (r) begin
            m_ph  = 0;
            m_cnt = 0;
            foreach (exp_q[i]) begin
                if (exp_q[i].stamp == cyc + 1) begin
                    exp_q[i].le   = 1'b0;
                    exp_q[i].addr = 0;
                    exp_q[i].ap   = 1'b0;
                    exp_q[i].dn   = 1'b0;
                    exp_q[i].req  = "R1";
                end
            end
        end else begin
            case (m_ph)
                0: if (s) begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == NW - 1) begin m_ph = 2; m_cnt = 0; end
                   else m_cnt = m_cnt + 1;
                2: m_ph = 3;
                default: if (!s) m_ph = 0;
            endcase
        end
        it.stamp = cyc + 2;
        it.le    = (m_ph == 1);
        it.addr  = (m_ph == 1) ? m_cnt : 0;
        it.ap    = (m_ph == 2);
        it.dn    = (m_ph == 3);
        it.req   = tag;
        if (tag == "R3" && it.ap) it.req = "R4";
        if (tag == "R3" && it.dn) it.req = "R5";
        exp_q.push_back(it);
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (mon_on && !finished) begin
            bit exp_mis;
            while (exp_q.size() > 0 && exp_q[0].stamp < cyc) void'(exp_q.pop_front());
            if (exp_q.size() > 0 && exp_q[0].stamp == cyc) begin
                item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (load_en !== it.le || int'(load_addr) != it.addr ||
                    apply !== it.ap || done !== it.dn) begin
                    n_errors++;
                    $display("FAIL %s cycle %0d: got le=%0b addr=%0d ap=%0b dn=%0b, expected le=%0b addr=%0d ap=%0b dn=%0b",
                             it.req, cyc, load_en, load_addr, apply, done,
                             it.le, it.addr, it.ap, it.dn);
                end
            end
            exp_mis = 1'b0;
            while (mis_q.size() > 0 && mis_q[0] < cyc) void'(mis_q.pop_front());
            if (mis_q.size() > 0 && mis_q[0] == cyc) begin
                exp_mis = 1'b1;
                void'(mis_q.pop_front());
            end
            n_checks++;
            if (mismatch !== exp_mis) begin
                n_errors++;
                $display("FAIL R9 cycle %0d: mismatch got %0b expected %0b", cyc, mismatch, exp_mis);
            end
        end
    end

    initial begin
        // R1: reset state
        tick(1'b0, 1'b1, -1, '0, "R1");
        mon_on = 1'b1;
        tick(1'b0, 1'b1, -1, '0, "R1");
        tick(1'b0, 1'b1, -1, '0, "R1");
        // R2: idle without a request
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, -1, '0, "R2");
        // R3/R4/R5: full sequence, request held through done
        for (int i = 0; i < 14; i++) tick(1'b1, 1'b0, -1, '0, "R3");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, -1, '0, "R5");
        // R6: short request pulse, sequence runs to completion
        tick(1'b1, 1'b0, -1, '0, "R6");
        for (int i = 0; i < 14; i++) tick(1'b0, 1'b0, -1, '0, "R6");
        // R7: single upsets in different copies during a run
        tick(1'b1, 1'b0, -1, '0, "R7");
        tick(1'b1, 1'b0, -1, '0, "R7");
        tick(1'b1, 1'b0, 0, 5'b00001, "R7");
        tick(1'b1, 1'b0, -1, '0, "R7");
        tick(1'b1, 1'b0, 2, 5'b10000, "R7");
        tick(1'b1, 1'b0, -1, '0, "R7");
        // R8: upsets in two copies on consecutive cycles
        tick(1'b1, 1'b0, 1, 5'b00110, "R8");
        tick(1'b1, 1'b0, 2, 5'b01000, "R8");
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, -1, '0, "R8");
        tick(1'b1, 1'b0, 0, 5'b01000, "R7");
        tick(1'b0, 1'b0, -1, '0, "R7");
        tick(1'b0, 1'b0, 1, 5'b00010, "R7");
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, -1, '0, "R7");
        // R1: reset in the middle of loading
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, -1, '0, "R3");
        tick(1'b1, 1'b1, -1, '0, "R1");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, -1, '0, "R1");
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, -1, '0, "R2");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule